// File: doc/BRIEF.md
# MSI Snoopy Cache-Line Controller

This block tracks the coherence state of every line in a small private write-back cache that shares a snooping bus with other masters. Each line is Modified, Shared or Invalid. Processor reads and writes hit locally when the state allows it. Otherwise the controller requests the bus and, once it holds the single-owner grant, performs one atomic transaction: a read, a read-for-ownership, or a writeback of a dirty victim.

When another master owns the bus slot, the controller looks up the snooped address. If it holds the line dirty, it supplies the data on a flush path that both the requester and memory capture in that same slot. The cache is direct-mapped with one data word per line. A processor request is held by the requester until it sees `cpu_ready_o`.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. With no requests, `cpu_ready_o`, `bus_req_o` and `snp_flush_o` are low, and `bus_cmd_o` is 0 (none).
- R2: A processor read that misses (line Invalid or tag differs, with no dirty victim) raises `bus_req_o`. In the granted cycle `bus_cmd_o` is 1 (read) with `bus_addr_o` equal to the request address, and `cpu_ready_o` rises in that same cycle with `cpu_rdata_o` equal to `bus_rdata_i`. The line becomes Shared and holds that data.
- R3: A processor read that hits a Shared or Modified line completes in the request cycle with the stored data and without raising `bus_req_o`.
- R4: A processor write to an Invalid or Shared line issues command 2 (read-exclusive) in its granted cycle and completes there. A write that hits a Modified line completes at once with no bus request. In both cases the line ends Modified and holds the written word.
- R5: A snooped command 1 (read) that hits a Modified line raises `snp_flush_o` in that cycle, with `snp_data_o` carrying the line data, and the line becomes Shared. A hit on a Shared line gives no flush and leaves the line Shared. `snp_data_o` is zero whenever `snp_flush_o` is low.
- R6: A snooped command 2 (read-exclusive) that hits a Modified line flushes its data and makes the line Invalid. A hit on a Shared line makes it Invalid without a flush.
- R7: A miss whose index holds a Modified line with another tag first spends a granted cycle on command 3 (writeback). That cycle carries the victim address and data, leaves the line Invalid, and does not complete the request. A later grant then performs the fill.
- R8: In a cycle where a snooped read or read-exclusive uses the same index as the pending processor request, the processor side neither completes nor requests the bus.
- R9: Snooped commands 0, 3 and 4, and snooped reads to a tag that is not held, cause no flush and leave the line state and data unchanged.
- R10: `bus_cmd_o` is non-zero only in a cycle where `bus_gnt_i` and `bus_req_o` are both high. While no grant is given, the request stays pending.
- R11: Sequence on one address X. Memory holds 10. This cache reads X and gets 10 from memory, Shared. Master B reads X: no flush. B writes X (snooped read-exclusive): this copy goes Invalid. This cache reads X again and receives -25 supplied by B, Shared. Master C reads X: no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request pending |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | Processor line address |
| cpu_wdata_i | input | DW | Processor write word |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DW | Read word, valid with ready on a read |
| bus_req_o | output | 1 | Request for the bus slot |
| bus_gnt_i | input | 1 | Slot granted to this cache |
| bus_cmd_o | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 writeback |
| bus_addr_o | output | AW | Address of the issued transaction |
| bus_wdata_o | output | DW | Writeback word, zero otherwise |
| bus_rdata_i | input | DW | Fill word returned in the granted slot |
| snp_cmd_i | input | 3 | Command of another master's slot (0..4, 4 = flush) |
| snp_addr_i | input | AW | Address of the snooped transaction |
| snp_flush_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DW | Flushed word |

## Verification
A wrong state bit surfaces at the ports no later than the next access to that line. A line left Modified after a snooped read shows a spurious flush on the next snoop. A line wrongly Shared issues an extra read-exclusive on a write. A line wrongly Invalid asks for the bus on a read that should hit. A stale data word appears on `cpu_rdata_o` or `snp_data_o` in the very cycle the line is read or flushed. For that reason a reference model of state, tag and data is compared against every output on every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_RD    = 3'd1,
    CMD_RDX   = 3'd2,
    CMD_WB    = 3'd3,
    CMD_FLUSH = 3'd4
  } bus_cmd_e;

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TW    = 6,
  parameter int DW    = 16,
  localparam int IW   = $clog2(LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  // snoop-side state update (wins over the processor port)
  input  logic                      snp_we,
  input  logic [IW-1:0]             snp_idx,
  input  line_st_e                  snp_st,
  // processor-side update
  input  logic                      cp_we,
  input  logic [IW-1:0]             cp_idx,
  input  line_st_e                  cp_st,
  input  logic                      cp_dat_en,
  input  logic [TW-1:0]             cp_tag,
  input  logic [DW-1:0]             cp_dat,
  // flat view of all lines
  output logic [LINES-1:0][1:0]     st_all,
  output logic [LINES-1:0][TW-1:0]  tag_all,
  output logic [LINES-1:0][DW-1:0]  dat_all
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e        st_q, st_d;
    logic [TW-1:0]   tag_q, tag_d;
    logic [DW-1:0]   dat_q, dat_d;
    logic            snp_sel, cp_sel;

    assign snp_sel = snp_we && (snp_idx == IW'(g));
    assign cp_sel  = cp_we  && (cp_idx  == IW'(g));

    always_comb begin
      st_d  = st_q;
      tag_d = tag_q;
      dat_d = dat_q;
      if (snp_sel) begin
        st_d = snp_st;
      end else if (cp_sel) begin
        st_d = cp_st;
        if (cp_dat_en) begin
          tag_d = cp_tag;
          dat_d = cp_dat;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= ST_I;
        tag_q <= '0;
        dat_q <= '0;
      end else if (snp_sel || cp_sel) begin
        st_q  <= st_d;
        tag_q <= tag_d;
        dat_q <= dat_d;
      end
    end

    assign st_all[g]  = st_q;
    assign tag_all[g] = tag_q;
    assign dat_all[g] = dat_q;
  end

endmodule

// File: rtl/msi_snoop_port.sv
module msi_snoop_port
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic [2:0]                snp_cmd,
  input  logic [AW-1:0]             snp_addr,
  input  logic [LINES-1:0][1:0]     st_all,
  input  logic [LINES-1:0][TW-1:0]  tag_all,
  input  logic [LINES-1:0][DW-1:0]  dat_all,
  output logic                      snp_act,
  output logic [IW-1:0]             snp_idx,
  output logic                      flush,
  output logic [DW-1:0]             flush_dat,
  output logic                      upd_we,
  output line_st_e                  upd_st
);

  bus_cmd_e      cmd;
  line_st_e      cur_st;
  logic [TW-1:0] s_tag;
  logic          hit;

  always_comb begin
    cmd     = bus_cmd_e'(snp_cmd);
    snp_idx = snp_addr[IW-1:0];
    s_tag   = snp_addr[AW-1:IW];
    cur_st  = line_st_e'(st_all[snp_idx]);
    snp_act = (cmd == CMD_RD) || (cmd == CMD_RDX);
    hit     = snp_act && (cur_st != ST_I) && (tag_all[snp_idx] == s_tag);
    flush   = hit && (cur_st == ST_M);
    flush_dat = flush ? dat_all[snp_idx] : '0;
    upd_we  = hit;
    upd_st  = (cmd == CMD_RD) ? ST_S : ST_I;
  end

endmodule

// File: rtl/msi_proc_ctrl.sv
module msi_proc_ctrl
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [AW-1:0]             cpu_addr,
  input  logic [DW-1:0]             cpu_wdata,
  output logic                      cpu_ready,
  output logic [DW-1:0]             cpu_rdata,
  output logic                      bus_req,
  input  logic                      bus_gnt,
  output bus_cmd_e                  bus_cmd,
  output logic [AW-1:0]             bus_addr,
  output logic [DW-1:0]             bus_wdata,
  input  logic [DW-1:0]             bus_rdata,
  input  logic                      snp_act,
  input  logic [IW-1:0]             snp_idx,
  input  logic [LINES-1:0][1:0]     st_all,
  input  logic [LINES-1:0][TW-1:0]  tag_all,
  input  logic [LINES-1:0][DW-1:0]  dat_all,
  output logic                      wr_en,
  output logic [IW-1:0]             wr_idx,
  output line_st_e                  wr_st,
  output logic                      wr_dat_en,
  output logic [TW-1:0]             wr_tag,
  output logic [DW-1:0]             wr_dat
);

  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  line_st_e      cur_st;
  logic [TW-1:0] cur_tag;
  logic [DW-1:0] cur_dat;
  logic          hit, need_bus, coll, victim_dirty, slot;

  // lookup and decision
  always_comb begin
    idx          = cpu_addr[IW-1:0];
    tag          = cpu_addr[AW-1:IW];
    cur_st       = line_st_e'(st_all[idx]);
    cur_tag      = tag_all[idx];
    cur_dat      = dat_all[idx];
    hit          = (cur_st != ST_I) && (cur_tag == tag);
    need_bus     = !hit || (cpu_we && (cur_st != ST_M));
    coll         = snp_act && (snp_idx == idx);
    victim_dirty = (cur_st == ST_M) && (cur_tag != tag);
  end

  // bus side
  always_comb begin
    bus_req   = cpu_req && need_bus && !coll;
    slot      = bus_req && bus_gnt;
    if (!slot)             bus_cmd = CMD_NONE;
    else if (victim_dirty) bus_cmd = CMD_WB;
    else if (cpu_we)       bus_cmd = CMD_RDX;
    else                   bus_cmd = CMD_RD;
    bus_addr  = victim_dirty ? {cur_tag, idx} : cpu_addr;
    bus_wdata = (bus_cmd == CMD_WB) ? cur_dat : '0;
  end

  // processor side and array update
  always_comb begin
    cpu_ready = cpu_req && !coll && (!need_bus || (slot && !victim_dirty));
    cpu_rdata = hit ? cur_dat : bus_rdata;
    wr_idx    = idx;
    wr_tag    = tag;
    wr_en     = (cpu_ready && (cpu_we || !hit)) || (bus_cmd == CMD_WB);
    wr_dat_en = (bus_cmd != CMD_WB);
    if (bus_cmd == CMD_WB) wr_st = ST_I;
    else if (cpu_we)       wr_st = ST_M;
    else                   wr_st = ST_S;
    wr_dat    = cpu_we ? cpu_wdata : bus_rdata;
  end

  // R10
  cmd_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != CMD_NONE) |-> (bus_gnt && bus_req));

  // R7
  wb_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_WB) |-> !cpu_ready);

  // R7
  wb_empties_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_WB) |=> (st_all[$past(idx)] == ST_I));

  // R4
  write_owns_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> (st_all[$past(idx)] == ST_M));

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [2:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic [2:0]    snp_cmd_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          snp_flush_o,
  output logic [DW-1:0] snp_data_o
);

  logic [LINES-1:0][1:0]    st_all;
  logic [LINES-1:0][TW-1:0] tag_all;
  logic [LINES-1:0][DW-1:0] dat_all;

  logic          snp_act, snp_upd_we;
  logic [IW-1:0] snp_idx;
  line_st_e      snp_upd_st;

  logic          wr_en, wr_dat_en;
  logic [IW-1:0] wr_idx;
  line_st_e      wr_st;
  logic [TW-1:0] wr_tag;
  logic [DW-1:0] wr_dat;
  bus_cmd_e      cmd;

  msi_line_array #(.LINES(LINES), .TW(TW), .DW(DW)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_we    (snp_upd_we),
    .snp_idx   (snp_idx),
    .snp_st    (snp_upd_st),
    .cp_we     (wr_en),
    .cp_idx    (wr_idx),
    .cp_st     (wr_st),
    .cp_dat_en (wr_dat_en),
    .cp_tag    (wr_tag),
    .cp_dat    (wr_dat),
    .st_all    (st_all),
    .tag_all   (tag_all),
    .dat_all   (dat_all)
  );

  msi_snoop_port #(.AW(AW), .DW(DW), .LINES(LINES)) u_snoop (
    .snp_cmd   (snp_cmd_i),
    .snp_addr  (snp_addr_i),
    .st_all    (st_all),
    .tag_all   (tag_all),
    .dat_all   (dat_all),
    .snp_act   (snp_act),
    .snp_idx   (snp_idx),
    .flush     (snp_flush_o),
    .flush_dat (snp_data_o),
    .upd_we    (snp_upd_we),
    .upd_st    (snp_upd_st)
  );

  msi_proc_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u_proc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req_i),
    .cpu_we    (cpu_we_i),
    .cpu_addr  (cpu_addr_i),
    .cpu_wdata (cpu_wdata_i),
    .cpu_ready (cpu_ready_o),
    .cpu_rdata (cpu_rdata_o),
    .bus_req   (bus_req_o),
    .bus_gnt   (bus_gnt_i),
    .bus_cmd   (cmd),
    .bus_addr  (bus_addr_o),
    .bus_wdata (bus_wdata_o),
    .bus_rdata (bus_rdata_i),
    .snp_act   (snp_act),
    .snp_idx   (snp_idx),
    .st_all    (st_all),
    .tag_all   (tag_all),
    .dat_all   (dat_all),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_st     (wr_st),
    .wr_dat_en (wr_dat_en),
    .wr_tag    (wr_tag),
    .wr_dat    (wr_dat)
  );

  assign bus_cmd_o = cmd;

  // R5
  snp_rd_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_flush_o && (snp_cmd_i == CMD_RD))
      |=> (st_all[$past(snp_addr_i[IW-1:0])] == ST_S));

  // R6
  snp_rdx_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_flush_o && (snp_cmd_i == CMD_RDX))
      |=> (st_all[$past(snp_addr_i[IW-1:0])] == ST_I));

  // R8
  snp_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && ((snp_cmd_i == CMD_RD) || (snp_cmd_i == CMD_RDX))
      && (snp_addr_i[IW-1:0] == cpu_addr_i[IW-1:0]))
      |-> (!cpu_ready_o && !bus_req_o));

  // R9
  no_idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((snp_cmd_i != CMD_RD) && (snp_cmd_i != CMD_RDX)) |-> !snp_flush_o);

endmodule

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LINES = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cpu_req_i, cpu_we_i, cpu_ready_o;
  logic [AW-1:0] cpu_addr_i;
  logic [DW-1:0] cpu_wdata_i, cpu_rdata_o;
  logic          bus_req_o, bus_gnt_i;
  logic [2:0]    bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, bus_rdata_i;
  logic [2:0]    snp_cmd_i;
  logic [AW-1:0] snp_addr_i;
  logic          snp_flush_o;
  logic [DW-1:0] snp_data_o;

  msi_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int ms [LINES];
  int mt [LINES];
  int md [LINES];
  int mem [256];
  int rd_src = -1;
  bit last_rdy;
  int last_rd;

  always_comb bus_rdata_i = (rd_src >= 0) ? DW'(rd_src) : DW'(mem[cpu_addr_i]);

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cyc();
    int idx, tg, si, stg, ecmd, erd;
    bit sact, shit, eflush, coll, hit, need, vd, ereq, slot, erdy;
    @(negedge clk);
    idx = int'(cpu_addr_i) % LINES;  tg  = int'(cpu_addr_i) / LINES;
    si  = int'(snp_addr_i) % LINES;  stg = int'(snp_addr_i) / LINES;
    sact   = rst_n && (snp_cmd_i == 3'd1 || snp_cmd_i == 3'd2);
    shit   = sact && ms[si] != 0 && mt[si] == stg;
    eflush = shit && ms[si] == 2;
    coll   = sact && si == idx;
    hit    = ms[idx] != 0 && mt[idx] == tg;
    need   = !hit || (cpu_we_i && ms[idx] != 2);
    vd     = ms[idx] == 2 && mt[idx] != tg;
    ereq   = rst_n && cpu_req_i && need && !coll;
    slot   = ereq && bus_gnt_i;
    ecmd   = slot ? (vd ? 3 : (cpu_we_i ? 2 : 1)) : 0;
    erdy   = rst_n && cpu_req_i && !coll && (!need || (slot && !vd));
    erd    = int'(bus_rdata_i);
    chk(cur_req, "cpu_ready", int'(cpu_ready_o), int'(erdy));
    chk(cur_req, "bus_req", int'(bus_req_o), int'(ereq));
    chk(cur_req, "bus_cmd", int'(bus_cmd_o), ecmd);
    chk(cur_req, "snp_flush", int'(snp_flush_o), int'(eflush));
    chk(cur_req, "snp_data", int'(snp_data_o), eflush ? md[si] : 0);
    if (ecmd != 0)
      chk(cur_req, "bus_addr", int'(bus_addr_o), vd ? mt[idx] * LINES + idx : int'(cpu_addr_i));
    if (ecmd == 3) chk(cur_req, "bus_wdata", int'(bus_wdata_o), md[idx]);
    if (erdy && !cpu_we_i) chk(cur_req, "cpu_rdata", int'(cpu_rdata_o), hit ? md[idx] : erd);
    last_rdy = cpu_ready_o;
    last_rd  = int'(cpu_rdata_o);
    @(posedge clk);
    if (shit) begin
      if (eflush) mem[int'(snp_addr_i)] = md[si];
      ms[si] = (snp_cmd_i == 3'd1) ? 1 : 0;
    end
    if (ecmd == 3) begin
      mem[mt[idx] * LINES + idx] = md[idx];
      ms[idx] = 0;
    end else if (erdy) begin
      if (cpu_we_i) begin
        ms[idx] = 2; mt[idx] = tg; md[idx] = int'(cpu_wdata_i);
      end else if (!hit) begin
        ms[idx] = 1; mt[idx] = tg; md[idx] = erd;
      end
    end
    #1;
  endtask

  task automatic op(bit we, int a, int d, int src, int gdly);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = AW'(a);
    cpu_wdata_i = DW'(d); rd_src = src;
    for (int k = 0; k < 40; k++) begin
      #1;
      bus_gnt_i = bus_req_o && (k >= gdly);
      cyc();
      bus_gnt_i = 1'b0;
      if (last_rdy) break;
    end
    cpu_req_i = 1'b0; rd_src = -1;
    cyc();
  endtask

  task automatic snp(int c, int a);
    snp_cmd_i = 3'(c); snp_addr_i = AW'(a);
    cyc();
    snp_cmd_i = 3'd0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung (actual=running, expected=finished)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin ms[i] = 0; mt[i] = 0; md[i] = 0; end
    for (int i = 0; i < 256; i++) mem[i] = (i * 37 + 5) & 16'hFFFF;
    rst_n = 1'b0; cpu_req_i = 0; cpu_we_i = 0; cpu_addr_i = '0; cpu_wdata_i = '0;
    bus_gnt_i = 0; snp_cmd_i = '0; snp_addr_i = '0;
    cur_req = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    cyc(); cyc();

    // R11: shared-read, invalidate and cache-to-cache sequence on X = 0x12
    cur_req = "R11";
    mem[8'h12] = 10;
    op(0, 8'h12, 0, -1, 0);
    chk("R11", "first read of X", last_rd, 10);
    snp(1, 8'h12);
    snp(2, 8'h12);
    op(0, 8'h12, 0, 16'hFFE7, 1);
    chk("R11", "read of X after remote write", last_rd, 16'hFFE7);
    snp(1, 8'h12);

    // R3: read hit in Shared
    cur_req = "R3";
    op(0, 8'h12, 0, -1, 0);
    chk("R3", "hit data", last_rd, 16'hFFE7);

    // R8: snoop on same index, other tag, stalls processor
    cur_req = "R8";
    cpu_req_i = 1; cpu_we_i = 0; cpu_addr_i = 8'h12;
    snp_cmd_i = 3'd1; snp_addr_i = 8'h16;
    cyc();
    chk("R8", "ready during colliding snoop", int'(last_rdy), 0);
    snp_cmd_i = 3'd0;
    cyc();
    cpu_req_i = 0;
    cyc();

    // R4: upgrade S->M by read-exclusive, then silent write in M
    cur_req = "R4";
    op(1, 8'h12, 16'h0042, -1, 2);
    op(1, 8'h12, 16'h0043, -1, 0);
    cur_req = "R3";
    op(0, 8'h12, 0, -1, 0);
    chk("R3", "read hit in M", last_rd, 16'h0043);

    // R5: snooped read on M flushes, line drops to S
    cur_req = "R5";
    snp(1, 8'h12);
    snp(1, 8'h12);
    chk("R5", "memory after flush", mem[8'h12], 16'h0043);

    // R6: snooped rdx on M flushes and invalidates
    cur_req = "R6";
    op(1, 8'h12, 16'h0099, -1, 0);
    snp(2, 8'h12);
    op(0, 8'h12, 0, 16'h0099, 0);
    snp(2, 8'h12);
    cur_req = "R2";
    op(0, 8'h12, 0, -1, 3);

    // R9: ignored snoops on a Modified line
    cur_req = "R9";
    op(1, 8'h21, 16'h1234, -1, 0);
    snp(3, 8'h21);
    snp(4, 8'h21);
    snp(0, 8'h21);
    snp(1, 8'h25);
    snp(2, 8'h25);
    op(0, 8'h21, 0, -1, 0);
    chk("R9", "data kept after ignored snoops", last_rd, 16'h1234);

    // R7: miss on a dirty victim writes back first
    cur_req = "R7";
    mem[8'h25] = 77;
    op(0, 8'h25, 0, -1, 0);
    chk("R7", "fill after writeback", last_rd, 77);
    chk("R7", "victim in memory", mem[8'h21], 16'h1234);
    op(1, 8'h31, 16'h0555, -1, 0);
    op(1, 8'h35, 16'h0666, -1, 2);

    // R10: long grant delay
    cur_req = "R10";
    op(0, 8'h40, 0, -1, 6);
    op(1, 8'h44, 16'h0777, -1, 4);
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule